// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers interrupt requests from a set of maskable sources and one non-maskable source, and decides which one the processor core services next. A rising edge on a request line records a pending flag. Each source has an enable bit. A single global-disable bit blocks every maskable source at once. The lowest-numbered source that is pending, enabled and not blocked is accepted. The non-maskable source ignores both the enable bits and the global disable, and it is always taken first.

When a source is accepted, the block drives an active-low acknowledge and a vector index to the core. The acknowledge and the index stay in place until the core signals that it has taken the interrupt. A one-cycle branch request asks the core to save its program counter and branch. The lower request lines, numbered 0 up to `NUM_HW-1`, stand for hardware pins. The upper lines model software interrupts. Accepting a hardware source, or the non-maskable source, sets the global disable by itself. A return input clears the global disable again.

Software reaches the pending flags and the enable bits through a small register port. It also drives a separate set/clear port for the global disable.

Top module: `maskable_intc`

## Requirements
- R1: A rising edge on `irq_req[i]` sets pending flag i at the next clock edge. A request held high afterwards produces no further pending event, even after that flag has been cleared.
- R2: Enable bit i = 1 lets source i be accepted, and enable bit i = 0 blocks it. The enable bits are written and read with `reg_sel` = 1.
- R3: While `gdis` = 1, no maskable source is accepted. `gdis` resets to 1. `gdis_set` sets it. `gdis_clr` or `rti` clears it. Acceptance of a hardware source, or `gdis_set`, takes priority over a clear in the same cycle.
- R4: A rising edge on `nmi_req` is accepted regardless of the enable bits and `gdis`. It wins over every pending maskable source, and its vector index equals `NUM_SRC`.
- R5: Accepting source i with i < `NUM_HW`, or accepting the non-maskable source, sets `gdis` at the acceptance edge. Accepting a source with i ≥ `NUM_HW` leaves `gdis` unchanged.
- R6: Among the eligible maskable sources, the lowest-numbered one is accepted. Its pending flag is cleared at the acceptance edge.
- R7: A write with `reg_sel` = 0 clears every pending flag whose `reg_wdata` bit is 1. Bits written as 0 leave their flags unchanged. The flags are read back with `reg_sel` = 0.
- R8: When a new request edge and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: `ack_n` goes low one cycle after a request becomes eligible while the controller is idle. `vec_idx` is valid at that time. Both hold until an edge at which `core_take` = 1, and `ack_n` returns high after that edge.
- R10: `branch_req` is high for exactly the first cycle of each acknowledge.
- R11: After reset, `ack_n` = 1, `branch_req` = 0, all pending flags are 0 and all enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Maskable request lines (hardware then software), edge-detected |
| nmi_req | input | 1 | Non-maskable request, edge-detected |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = pending flags, 1 = enable bits |
| reg_wdata | input | NUM_SRC | Write data (write-1-clear for flags) |
| reg_rdata | output | NUM_SRC | Read data of the selected register |
| gdis_set | input | 1 | Set the global disable |
| gdis_clr | input | 1 | Clear the global disable |
| rti | input | 1 | Return from interrupt, clears the global disable |
| gdis | output | 1 | Global disable state |
| ack_n | output | 1 | Active-low acknowledge |
| vec_idx | output | VEC_W | Index of the accepted source (NUM_SRC = non-maskable) |
| branch_req | output | 1 | One-cycle request to save the PC and branch |
| core_take | input | 1 | Core has taken the interrupt; ends the acknowledge |

## Verification
The bench sweeps every enable pattern with all flags pending and checks each of the following:
- The accepted index, the cleared flag and the global-disable state after the core takes the interrupt. A selector that picks the wrong priority, or that ignores an enable bit, names the wrong source. A design that treats hardware and software sources alike leaves `gdis` wrong for sources 6 and 7.
- That a held request stays quiet once its flag is cleared. A level-sensitive input would set the flag again at once.
- A clear colliding with a new edge, where a design that favours the clear loses the event.
- A non-maskable request arriving under full blocking and alongside maskable requests, where a design that gates it would never acknowledge.
- The return input, where a design that does not re-enable would leave later requests stuck.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int MAX_SRC = 32;

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } ack_state_e;

    // One-hot of a source index, widest supported size.
    function automatic logic [MAX_SRC-1:0] idx_onehot(input int unsigned idx);
        logic [MAX_SRC-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_SRC; i++) begin
            if (idx == i) r[i] = 1'b1;
        end
        return r;
    endfunction

    // Bits strictly below a source index.
    function automatic logic [MAX_SRC-1:0] idx_below(input int unsigned idx);
        logic [MAX_SRC-1:0] r;
        r = '0;
        for (int i = 0; i < MAX_SRC; i++) begin
            if (i < idx) r[i] = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_edge_det.sv
module intc_edge_det #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] ack_clr,
    output logic [W-1:0] flags
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                         flags[i] <= 1'b0;
            else if (set_ev[i])              flags[i] <= 1'b1;   // new event wins
            else if (sw_clr[i] || ack_clr[i]) flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 4
) (
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] mask,
    input  logic               gdis,
    input  logic               nmi_pend,
    output logic               valid,
    output logic               is_nmi,
    output logic [VEC_W-1:0]   vec
);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

    logic [NUM_SRC-1:0] elig;
    assign elig = gdis ? '0 : (flags & mask);

    always_comb begin
        valid  = nmi_pend || (|elig);
        is_nmi = nmi_pend;
        vec    = NMI_VEC;
        if (!nmi_pend) begin
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
                if (elig[i]) vec = VEC_W'(i);
            end
        end
    end
endmodule

// File: rtl/maskable_intc.sv
module maskable_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_HW  = 6,
    parameter int VEC_W   = $clog2(NUM_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic               nmi_req,
    input  logic               reg_wr,
    input  logic               reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic               gdis_set,
    input  logic               gdis_clr,
    input  logic               rti,
    output logic               gdis,
    output logic               ack_n,
    output logic [VEC_W-1:0]   vec_idx,
    output logic               branch_req,
    input  logic               core_take
);
    localparam int               EW      = NUM_SRC + 1;
    localparam logic [VEC_W-1:0] HW_LIM  = VEC_W'(NUM_HW);

    reg_sel_e           sel;
    ack_state_e         state_q;
    logic [EW-1:0]      rise;
    logic [NUM_SRC-1:0] flag_q, mask_q, sw_clr, ack_clr;
    logic               gdis_q, nmi_pend_q, branch_q;
    logic [VEC_W-1:0]   vec_q;
    logic               pick_valid, pick_nmi, accept, accept_hw;
    logic [VEC_W-1:0]   pick_vec;
    logic [MAX_SRC-1:0] pick_oh;

    assign sel = reg_sel_e'(reg_sel);

    intc_edge_det #(.W(EW)) edge_i (
        .clk (clk),
        .rst (rst),
        .lvl ({nmi_req, irq_req}),
        .rise(rise)
    );

    intc_pick #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) pick_i (
        .flags   (flag_q),
        .mask    (mask_q),
        .gdis    (gdis_q),
        .nmi_pend(nmi_pend_q),
        .valid   (pick_valid),
        .is_nmi  (pick_nmi),
        .vec     (pick_vec)
    );

    assign accept    = (state_q == ST_IDLE) && pick_valid;
    assign accept_hw = accept && (pick_nmi || (pick_vec < HW_LIM));
    assign pick_oh   = idx_onehot(int'(pick_vec));
    assign ack_clr   = (accept && !pick_nmi) ? pick_oh[NUM_SRC-1:0] : '0;
    assign sw_clr    = (reg_wr && sel == SEL_FLAG) ? reg_wdata : '0;

    intc_flag_bank #(.W(NUM_SRC)) flag_i (
        .clk    (clk),
        .rst    (rst),
        .set_ev (rise[NUM_SRC-1:0]),
        .sw_clr (sw_clr),
        .ack_clr(ack_clr),
        .flags  (flag_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                            mask_q <= '0;
        else if (reg_wr && sel == SEL_MASK) mask_q <= reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                    gdis_q <= 1'b1;
        else if (accept_hw || gdis_set) gdis_q <= 1'b1;
        else if (gdis_clr || rti)   gdis_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)                        nmi_pend_q <= 1'b0;
        else if (rise[NUM_SRC])         nmi_pend_q <= 1'b1;
        else if (accept && pick_nmi)    nmi_pend_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            vec_q    <= '0;
            branch_q <= 1'b0;
        end else begin
            branch_q <= accept;
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_ACK;
                    vec_q   <= pick_vec;
                end
                ST_ACK: if (core_take) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign reg_rdata  = (sel == SEL_FLAG) ? flag_q : mask_q;
    assign gdis       = gdis_q;
    assign ack_n      = (state_q != ST_ACK);
    assign vec_idx    = vec_q;
    assign branch_req = branch_q;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int NUM_SRC = 8,
    parameter int NUM_HW  = 6,
    parameter int VEC_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               ack_n,
    input logic [VEC_W-1:0]   vec_idx,
    input logic               core_take,
    input logic               gdis,
    input logic               branch_req,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] mask,
    input logic               nmi_pend
);
    localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);
    localparam logic [VEC_W-1:0] HW_LIM  = VEC_W'(NUM_HW);

    logic [NUM_SRC-1:0] flag_d, mask_d, sel_oh, below;
    logic               gdis_d, nmi_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_d <= '0;
            mask_d <= '0;
            gdis_d <= 1'b1;
            nmi_d  <= 1'b0;
        end else begin
            flag_d <= flags;
            mask_d <= mask;
            gdis_d <= gdis;
            nmi_d  <= nmi_pend;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            sel_oh[i] = (vec_idx == VEC_W'(i));
            below[i]  = (VEC_W'(i) < vec_idx);
        end
    end

    // R9: acknowledge and index hold until the core takes it
    p_ack_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !core_take) |=> (!ack_n && $stable(vec_idx)));

    // R2 and R3: an accepted maskable source was pending, enabled, not globally blocked
    p_eligible_only_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_n) && vec_idx != NMI_VEC) |->
            (!gdis_d && (|(sel_oh & mask_d & flag_d))));

    // R4: pending non-maskable always wins
    p_nmi_first_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_n) && nmi_d) |-> (vec_idx == NMI_VEC));

    // R5: hardware acceptance leaves the global disable set
    p_hw_sets_gdis_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_n) && (vec_idx < HW_LIM || vec_idx == NMI_VEC)) |-> gdis);

    // R6: no lower-numbered eligible source was passed over
    p_lowest_wins_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(ack_n) && vec_idx != NMI_VEC) |-> ((flag_d & mask_d & below) == '0));

    // R10: branch request marks only the first acknowledge cycle
    p_branch_first_r10: assert property (@(posedge clk) disable iff (rst)
        branch_req |-> ($fell(ack_n) && !$past(branch_req)));
endmodule

bind maskable_intc intc_checker #(
    .NUM_SRC(NUM_SRC),
    .NUM_HW (NUM_HW),
    .VEC_W  (VEC_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ack_n     (ack_n),
    .vec_idx   (vec_idx),
    .core_take (core_take),
    .gdis      (gdis),
    .branch_req(branch_req),
    .flags     (flag_q),
    .mask      (mask_q),
    .nmi_pend  (nmi_pend_q)
);

// File: tb/maskable_intc_tb.sv
`timescale 1ns/1ps
module maskable_intc_tb_top;
    localparam int NS = 8;
    localparam int NH = 6;
    localparam int VW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] irq_req = '0;
    logic          nmi_req = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic          gdis_set = 1'b0, gdis_clr = 1'b0, rti = 1'b0;
    logic          gdis, ack_n, branch_req;
    logic          core_take = 1'b0;
    logic [VW-1:0] vec_idx;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    maskable_intc #(.NUM_SRC(NS), .NUM_HW(NH)) dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .nmi_req(nmi_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .gdis_set(gdis_set), .gdis_clr(gdis_clr),
        .rti(rti), .gdis(gdis), .ack_n(ack_n), .vec_idx(vec_idx),
        .branch_req(branch_req), .core_take(core_take)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; irq_req = '0; nmi_req = 1'b0; reg_wr = 1'b0;
        gdis_set = 1'b0; gdis_clr = 1'b0; rti = 1'b0; core_take = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [NS-1:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [NS-1:0] d);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [NS-1:0] d;
        tick();
        do_reset();

        // R11: reset state
        chk("R11 ack_n", ack_n, 1);
        chk("R11 branch_req", branch_req, 0);
        chk("R3 gdis reset", gdis, 1);
        rd(1'b0, d); chk("R11 flags", d, 0);
        rd(1'b1, d); chk("R11 mask", d, 0);

        // Sweep all enable patterns with every flag pending
        for (int m = 0; m < (1 << NS); m++) begin
            int w;
            logic [NS-1:0] mv;
            mv = NS'(m);
            w = -1;
            for (int b = NS - 1; b >= 0; b--) if (mv[b]) w = b;
            do_reset();
            wr(1'b1, mv);
            rd(1'b1, d); chk("R2 mask readback", d, mv);
            irq_req = '1;
            tick();                          // flags set, gdis still 1
            rd(1'b0, d); chk("R1 flags set", d, 8'hFF);
            chk("R3 blocked while gdis", ack_n, 1);
            gdis_clr = 1'b1; tick(); gdis_clr = 1'b0;
            chk("R3 cleared", gdis, 0);
            tick();                          // decision edge
            if (w < 0) begin
                chk("R2 all masked no ack", ack_n, 1);
            end else begin
                chk("R9 ack low", ack_n, 0);
                chk("R6 lowest index", vec_idx, w);
                chk("R10 branch pulse", branch_req, 1);
                tick();
                chk("R9 hold", ack_n, 0);
                chk("R9 vec stable", vec_idx, w);
                chk("R10 branch single", branch_req, 0);
                core_take = 1'b1; tick(); core_take = 1'b0;
                chk("R9 release", ack_n, 1);
                chk("R5 gdis after accept", gdis, (w < NH) ? 1 : 0);
                rd(1'b0, d);
                chk("R6 flag cleared, R1 no re-trigger", d, 8'hFF & ~(8'h01 << w));
            end
        end

        // R7 and R8: write-1-clear and collision with a new edge
        do_reset();
        irq_req = '1; tick(); irq_req = '0; tick();
        wr(1'b0, 8'h05);
        rd(1'b0, d); chk("R7 write-1-clear", d, 8'hFA);
        wr(1'b0, 8'h00);
        rd(1'b0, d); chk("R7 zero bits no effect", d, 8'hFA);
        irq_req = 8'h01;
        wr(1'b0, 8'h01);
        rd(1'b0, d); chk("R8 set beats clear", d, 8'hFB);

        // R4: non-maskable under full blocking
        do_reset();
        nmi_req = 1'b1; tick(); tick();
        chk("R4 nmi ack", ack_n, 0);
        chk("R4 nmi vec", vec_idx, NS);
        core_take = 1'b1; tick(); core_take = 1'b0;
        chk("R5 nmi gdis", gdis, 1);
        nmi_req = 1'b0;

        // R4 priority over maskables, then R3 return re-enables
        do_reset();
        wr(1'b1, 8'hFF);
        irq_req = 8'h01; nmi_req = 1'b1; gdis_clr = 1'b1;
        tick(); gdis_clr = 1'b0;
        tick();
        chk("R4 nmi wins", vec_idx, NS);
        core_take = 1'b1; tick(); core_take = 1'b0;
        chk("R5 gdis after nmi", gdis, 1);
        tick(); tick();
        chk("R3 gdis holds off", ack_n, 1);
        rti = 1'b1; tick(); rti = 1'b0;
        chk("R3 rti clears gdis", gdis, 0);
        tick();
        chk("R3 accept after rti", ack_n, 0);
        chk("R6 source 0 after rti", vec_idx, 0);
        core_take = 1'b1; tick(); core_take = 1'b0;

        // R3: gdis_set beats clear in the same cycle
        gdis_clr = 1'b1; tick(); gdis_clr = 1'b0;
        gdis_set = 1'b1; gdis_clr = 1'b1; tick();
        gdis_set = 1'b0; gdis_clr = 1'b0;
        chk("R3 set beats clear", gdis, 1);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule